// File: doc/BRIEF.md
# Multi-Cycle Integer Divider

This block divides an accumulator-style dividend by a narrower divisor, in two sizes and two number systems. In byte mode a 16-bit dividend is divided by an 8-bit divisor. In word mode a 32-bit dividend, given as a high word and a low word, is divided by a 16-bit divisor. Either size runs unsigned or signed. The core is a restoring divider that retires one quotient bit per clock. Signed operands are reduced to magnitudes before the core runs, and the signs are applied again when it finishes.

The result is packed as one vector, with the quotient in the lower half and the remainder in the upper half. A zero divisor, or a quotient that does not fit its destination, raises a divide-error output in place of a result. The caller pulses `start` while the unit is idle and waits for the one-cycle `done` pulse. Arithmetic flags are not produced.

The controller has three states. ST_IDLE waits for start. ST_ITER runs one core step per cycle. ST_FIX applies signs, checks the range, and registers the outputs. The transitions are: launch_to_iter (ST_IDLE to ST_ITER on start with operands that pass the pre-check), launch_to_fix (ST_IDLE to ST_FIX on start with a zero divisor or a pre-check overflow), iter_to_fix (ST_ITER to ST_FIX after the last step), and fix_to_idle (ST_FIX to ST_IDLE always).

Top module: `int_divider`

## Requirements
- R1: In byte mode (word_mode=0), dividend_lo[15:0] is divided by divisor[7:0]. The result is result[7:0]=quotient, result[15:8]=remainder and result[31:16]=0. dividend_hi and divisor[15:8] are ignored.
- R2: In word mode (word_mode=1), {dividend_hi,dividend_lo} is divided by divisor[15:0]. The result is result[15:0]=quotient and result[31:16]=remainder.
- R3: A zero divisor raises div_error together with done. Only divisor[7:0] is considered in byte mode.
- R4: In unsigned mode (signed_mode=0), a quotient above 255 (byte mode) or above 65535 (word mode) raises div_error.
- R5: In signed mode (signed_mode=1), operands are two's complement. The quotient truncates toward zero. The remainder takes the sign of the dividend and has a magnitude below that of the divisor.
- R6: A signed quotient must lie in -128..127 (byte mode) or -32768..32767 (word mode), otherwise div_error is raised. A magnitude of 128 or 32768 is accepted only for a negative quotient.
- R7: On div_error, result keeps its previous value. div_error is never high without done.
- R8: done is a single-cycle pulse. Take the rising edge that samples start as edge 0. When the divisor is zero or the quotient magnitude is at least 256 (byte mode) or 65536 (word mode), done rises after edge 1. Otherwise it rises after edge 9 in byte mode and after edge 17 in word mode.
- R9: A start pulse, or a change of operands, while an operation is in progress has no effect on that operation's result or timing.
- R10: After reset, result is 0 and done and div_error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| word_mode | input | 1 | 1 = 32/16 division, 0 = 16/8 division |
| signed_mode | input | 1 | 1 = two's complement operands |
| dividend_hi | input | 16 | Upper dividend word (word mode only) |
| dividend_lo | input | 16 | Lower dividend word, or the whole dividend in byte mode |
| divisor | input | 16 | Divisor; only bits 7:0 are used in byte mode |
| result | output | 32 | Packed quotient (low half) and remainder (high half) |
| done | output | 1 | One-cycle completion pulse |
| div_error | output | 1 | Divide error, valid with done |

## Verification
Each scenario task raises start for one cycle and then counts falling edges until done appears. The count must equal 1 for the fast error path, 9 for a byte division and 17 for a word division, including signed divisions that fail the range check. The result and div_error are sampled on the falling edge where done is first seen, midway between the registering edge and the next one. The following falling edge confirms that done has already dropped. The busy test changes the operands and pulses start in the fourth cycle of a word division, then still expects the first division's result at count 17.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
    parameter int W = 16
) (
    input  logic         word_mode,
    input  logic         signed_mode,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] part_hi,
    output logic [W-1:0] part_lo,
    output logic [W-1:0] dvs_mag,
    output logic         dvd_neg,
    output logic         dvs_neg,
    output logic         div_zero,
    output logic         hi_ovf
);
    localparam int H = W / 2;

    logic [2*W-1:0] wide_raw;
    logic [2*W-1:0] wide_mag;
    logic [W-1:0]   narrow_mag;
    logic [H-1:0]   dvs_small_mag;

    always_comb begin
        wide_raw      = {dvd_hi, dvd_lo};
        wide_mag      = '0;
        narrow_mag    = '0;
        dvs_small_mag = '0;
        if (word_mode) begin
            dvd_neg  = signed_mode & dvd_hi[W-1];
            dvs_neg  = signed_mode & dvs[W-1];
            wide_mag = dvd_neg ? (~wide_raw + 1'b1) : wide_raw;
            part_hi  = wide_mag[2*W-1:W];
            part_lo  = wide_mag[W-1:0];
            dvs_mag  = dvs_neg ? (~dvs + 1'b1) : dvs;
        end else begin
            dvd_neg       = signed_mode & dvd_lo[W-1];
            dvs_neg       = signed_mode & dvs[H-1];
            narrow_mag    = dvd_neg ? (~dvd_lo + 1'b1) : dvd_lo;
            part_hi       = {{H{1'b0}}, narrow_mag[W-1:H]};
            part_lo       = {narrow_mag[H-1:0], {H{1'b0}}};
            dvs_small_mag = dvs_neg ? (~dvs[H-1:0] + 1'b1) : dvs[H-1:0];
            dvs_mag       = {{H{1'b0}}, dvs_small_mag};
        end
        div_zero = (dvs_mag == '0);
        hi_ovf   = (part_hi >= dvs_mag);
    end
endmodule

// File: rtl/div_shift_core.sv
module div_shift_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_hi,
    input  logic [W-1:0] load_lo,
    input  logic [W-1:0] load_dvs,
    output logic [W-1:0] rem_mag,
    output logic [W-1:0] quo_mag
);
    logic [W-1:0] rem_q, lo_q, quo_q, dvs_q;
    logic [W:0]   trial;
    logic         fits;
    logic [W-1:0] diff;

    always_comb begin
        trial = {rem_q, lo_q[W-1]};
        fits  = (trial >= {1'b0, dvs_q});
        diff  = trial[W-1:0] - dvs_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            lo_q  <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= load_hi;
            lo_q  <= load_lo;
            quo_q <= '0;
            dvs_q <= load_dvs;
        end else if (step) begin
            rem_q <= fits ? diff : trial[W-1:0];
            lo_q  <= {lo_q[W-2:0], 1'b0};
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    assign rem_mag = rem_q;
    assign quo_mag = quo_q;

    // R5
    rem_below_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q < dvs_q));
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int W = 16
) (
    input  logic           word_mode,
    input  logic           signed_mode,
    input  logic           dvd_neg,
    input  logic           dvs_neg,
    input  logic [W-1:0]   q_mag,
    input  logic [W-1:0]   r_mag,
    output logic [2*W-1:0] packed_res,
    output logic           range_err
);
    localparam int H = W / 2;
    localparam logic [W-1:0] W_POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] W_NEG_MAX = {1'b1, {(W-1){1'b0}}};
    localparam logic [H-1:0] H_POS_MAX = {1'b0, {(H-1){1'b1}}};
    localparam logic [H-1:0] H_NEG_MAX = {1'b1, {(H-1){1'b0}}};

    logic         q_neg;
    logic [W-1:0] q_fix, r_fix;

    always_comb begin
        q_neg = signed_mode & (dvd_neg ^ dvs_neg);
        q_fix = q_neg   ? (~q_mag + 1'b1) : q_mag;
        r_fix = dvd_neg ? (~r_mag + 1'b1) : r_mag;
        if (word_mode) begin
            range_err  = signed_mode & (q_mag > (q_neg ? W_NEG_MAX : W_POS_MAX));
            packed_res = {r_fix, q_fix};
        end else begin
            range_err  = signed_mode & (q_mag[H-1:0] > (q_neg ? H_NEG_MAX : H_POS_MAX));
            packed_res = {{W{1'b0}}, r_fix[H-1:0], q_fix[H-1:0]};
        end
    end
endmodule

// File: rtl/int_divider.sv
module int_divider
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           word_mode,
    input  logic           signed_mode,
    input  logic [W-1:0]   dividend_hi,
    input  logic [W-1:0]   dividend_lo,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] result,
    output logic           done,
    output logic           div_error
);
    localparam int H  = W / 2;
    localparam int CW = $clog2(W + 1);

    div_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic mode_w_q, mode_s_q, dvd_neg_q, dvs_neg_q, pre_err_q;

    logic [W-1:0]   part_hi, part_lo, dvs_mag, rem_mag, quo_mag;
    logic           dvd_neg, dvs_neg, div_zero, hi_ovf, range_err, launch;
    logic [2*W-1:0] packed_res;

    assign launch = (state == ST_IDLE) && start;

    div_sign_prep #(.W(W)) u_prep (
        .word_mode  (word_mode),
        .signed_mode(signed_mode),
        .dvd_hi     (dividend_hi),
        .dvd_lo     (dividend_lo),
        .dvs        (divisor),
        .part_hi    (part_hi),
        .part_lo    (part_lo),
        .dvs_mag    (dvs_mag),
        .dvd_neg    (dvd_neg),
        .dvs_neg    (dvs_neg),
        .div_zero   (div_zero),
        .hi_ovf     (hi_ovf)
    );

    div_shift_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .step    (state == ST_ITER),
        .load_hi (part_hi),
        .load_lo (part_lo),
        .load_dvs(dvs_mag),
        .rem_mag (rem_mag),
        .quo_mag (quo_mag)
    );

    div_sign_fix #(.W(W)) u_fix (
        .word_mode  (mode_w_q),
        .signed_mode(mode_s_q),
        .dvd_neg    (dvd_neg_q),
        .dvs_neg    (dvs_neg_q),
        .q_mag      (quo_mag),
        .r_mag      (rem_mag),
        .packed_res (packed_res),
        .range_err  (range_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = (div_zero || hi_ovf) ? ST_FIX : ST_ITER;
            ST_ITER: if (cnt == CW'(1)) nxt = ST_FIX;
            ST_FIX:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            mode_w_q  <= 1'b0;
            mode_s_q  <= 1'b0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            pre_err_q <= 1'b0;
        end else if (launch) begin
            cnt       <= word_mode ? CW'(W) : CW'(H);
            mode_w_q  <= word_mode;
            mode_s_q  <= signed_mode;
            dvd_neg_q <= dvd_neg;
            dvs_neg_q <= dvs_neg;
            pre_err_q <= div_zero | hi_ovf;
        end else if (state == ST_ITER) begin
            cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            done      <= 1'b0;
            div_error <= 1'b0;
        end else begin
            done      <= 1'b0;
            div_error <= 1'b0;
            if (state == ST_FIX) begin
                done      <= 1'b1;
                div_error <= pre_err_q | range_err;
                if (!(pre_err_q | range_err)) result <= packed_res;
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_error |-> done);
    // R7
    hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_error) |-> $stable(result));
    // R3
    zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && div_zero) |=> (state == ST_FIX));
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ITER && cnt != CW'(1)) |=> (state == ST_ITER));
endmodule

// File: tb/int_divider_bench.sv
module int_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_mode = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] dividend_hi = '0;
    logic [15:0] dividend_lo = '0;
    logic [15:0] divisor = '0;
    logic [31:0] result;
    logic        done;
    logic        div_error;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] exp_prev = '0;

    always #4 clk = ~clk;

    int_divider u_int_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
        .signed_mode(signed_mode), .dividend_hi(dividend_hi),
        .dividend_lo(dividend_lo), .divisor(divisor), .result(result),
        .done(done), .div_error(div_error)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit wm, input bit sm, input logic [15:0] hi,
                          input logic [15:0] lo, input logic [15:0] dv,
                          input string req, input bit poke);
        longint a, d, q, r, lim_hi, lim_lo, full;
        bit exp_err, fast;
        int n, exp_lat, wcnt;
        logic [31:0] exp_res;
        n = wm ? 16 : 8;
        if (wm) begin
            a = sm ? longint'($signed({hi, lo})) : longint'({hi, lo});
            d = sm ? longint'($signed(dv)) : longint'(dv);
        end else begin
            a = sm ? longint'($signed(lo)) : longint'(lo);
            d = sm ? longint'($signed(dv[7:0])) : longint'(dv[7:0]);
        end
        full = longint'(1) << n;
        q = 0; r = 0;
        if (d != 0) begin q = a / d; r = a % d; end
        fast = (d == 0) || (q >= full) || (-q >= full);
        lim_hi = sm ? (full / 2 - 1) : (full - 1);
        lim_lo = sm ? -(full / 2) : 0;
        exp_err = (d == 0) || (q > lim_hi) || (q < lim_lo);
        exp_lat = fast ? 1 : n + 1;
        if (exp_err) exp_res = exp_prev;
        else if (wm) exp_res = {r[15:0], q[15:0]};
        else         exp_res = {16'h0, r[7:0], q[7:0]};

        @(negedge clk);
        word_mode = wm; signed_mode = sm;
        dividend_hi = hi; dividend_lo = lo; divisor = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wcnt = 0;
        while (!done && wcnt < 40) begin
            @(negedge clk);
            wcnt++;
            if (poke && wcnt == 3) begin
                start = 1'b1; dividend_lo = ~lo; divisor = dv + 16'd3;
            end else begin
                start = 1'b0;
            end
        end
        chk(wcnt == exp_lat, {req, " R8 latency"}, wcnt, exp_lat);
        chk(result == exp_res, {req, " result"}, result, exp_res);
        chk(div_error == exp_err, {req, " div_error R7"}, div_error, exp_err);
        if (!exp_err) exp_prev = exp_res;
        @(negedge clk);
        chk(done == 1'b0, "R8 done pulse width", done, 0);
    endtask

    task automatic t_reset();
        chk(result == 32'h0, "R10 result", result, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(div_error == 1'b0, "R10 div_error", div_error, 0);
    endtask

    task automatic t_byte_unsigned();
        run_op(0, 0, 16'h0000, 16'd100, 16'd7, "R1 100/7", 0);
        run_op(0, 0, 16'hABCD, 16'hFEFF, 16'h12FF, "R1 max byte quotient", 0);
    endtask

    task automatic t_word_unsigned();
        run_op(1, 0, 16'h0001, 16'h0000, 16'h0002, "R2 65536/2", 0);
        run_op(1, 0, 16'hFFFE, 16'hFFFF, 16'hFFFF, "R2 max word quotient", 0);
        run_op(1, 0, 16'h0012, 16'h3456, 16'h1234, "R2 mixed", 0);
    endtask

    task automatic t_zero();
        run_op(0, 0, 16'h0000, 16'd55, 16'h0100, "R3 byte zero (upper divisor ignored)", 0);
        run_op(1, 1, 16'h0000, 16'd55, 16'h0000, "R3 word zero", 0);
    endtask

    task automatic t_unsigned_ovf();
        run_op(1, 0, 16'h0001, 16'h0000, 16'h0001, "R4 word overflow", 0);
        run_op(0, 0, 16'h0000, 16'hFFFF, 16'h00FF, "R4 byte overflow", 0);
    endtask

    task automatic t_signed();
        run_op(0, 1, 16'h0000, 16'hFFF9, 16'h0002, "R5 -7/2", 0);
        run_op(0, 1, 16'h0000, 16'h0007, 16'h00FE, "R5 7/-2", 0);
        run_op(0, 1, 16'h0000, 16'hFFF9, 16'h00FE, "R5 -7/-2", 0);
        run_op(1, 1, 16'hFFFE, 16'h7960, 16'h0007, "R5 -100000/7", 0);
    endtask

    task automatic t_signed_range();
        run_op(0, 1, 16'h0000, 16'hFF80, 16'h0001, "R6 byte -128 ok", 0);
        run_op(0, 1, 16'h0000, 16'h0080, 16'h0001, "R6 byte +128 err", 0);
        run_op(0, 1, 16'h0000, 16'hFF80, 16'h00FF, "R6 byte -128/-1 err", 0);
        run_op(1, 1, 16'hFFFF, 16'h8000, 16'h0001, "R6 word -32768 ok", 0);
        run_op(1, 1, 16'h0000, 16'h8000, 16'h0001, "R6 word +32768 err", 0);
        run_op(1, 1, 16'h8000, 16'h0000, 16'hFFFF, "R6 word huge err", 0);
    endtask

    task automatic t_busy();
        run_op(1, 0, 16'h0003, 16'h1111, 16'h0101, "R9 start while busy", 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_unsigned();
        t_word_unsigned();
        t_zero();
        t_unsigned_ovf();
        t_signed();
        t_signed_range();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule